// File: doc/BRIEF.md
# Microstepping DAC Write Front End

This block is the digital side of a two-channel current DAC used for microstepping a motor. A processor writes to it over an 8-bit parallel bus with an active-low select, a write strobe and two address lines. The address lines pick a channel and a register. Each channel holds three values: a 7-bit current code, a direction flag and a 3-bit threshold. The threshold sets the level below which a falling code asks the motor driver for fast current decay.

Every time a new current code is written, the block compares it with the code it replaces and with that channel's threshold. It then registers an active-low decay flag for the driver. The bus pins are asynchronous to the system clock, so they first pass through a synchronizer. A write happens once, on the rising edge of the synchronized strobe.

Top module: `ustep_dac_front`

## Requirements
- R1: A write occurs only on a rising edge of `wrStrobe` while `chipSelN` is low. With `chipSelN` high, no output changes.
- R2: `chanSel` low addresses channel 0 (bit 0 of each per-channel output). `chanSel` high addresses channel 1.
- R3: `regSel` low targets the current-code register. `regSel` high targets the threshold register.
- R4: A code write sets `signOut` to data bit 7 unchanged and sets `dacCode` to data bits 6..0.
- R5: A threshold write stores data bits 6..4 as the 3-bit threshold and ignores the other data bits. It leaves `dacCode` and `signOut` unchanged.
- R6: On each code write, `decayN` becomes 0 only when the new 7-bit code is strictly less than the stored code and the new code's bits 6..4 are strictly less than the threshold. Otherwise `decayN` becomes 1.
- R7: A threshold write does not change `decayN`.
- R8: While `rst` is high (active high, synchronous), the following are set:
  - `dacCode`, `signOut` and the thresholds are set to 0.
  - `decayN` is set to 1.
- R9: Writes have a fixed latency and a held strobe writes only once.
  - A strobe rise that is stable before clock edge k updates the outputs at edge k+2.
  - A strobe held high writes exactly once, even if the data changes while it is held.
- R10: A write to one channel never changes the other channel's code, sign, threshold or decay flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wrStrobe | input | 1 | Write strobe, asynchronous; rising edge writes |
| chipSelN | input | 1 | Chip select, active low, asynchronous |
| chanSel | input | 1 | Channel address (0 = channel 0, 1 = channel 1) |
| regSel | input | 1 | Register address (0 = code, 1 = threshold) |
| dataBus | input | 8 | Write data |
| dacCode | output | 2x7 | Per-channel current code |
| signOut | output | 2 | Per-channel direction flag |
| decayN | output | 2 | Per-channel decay flag, 0 = fast decay |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a 7-bit code and a 3-bit threshold. With these values the full code range 0..127 is reachable, and every threshold value from 0 to 7 can be written. Directed writes land exactly on the strict-less-than boundaries of both comparisons: equal codes, and upper bits equal to the threshold. A behavioural model, driven from the same samples of the raw pins, follows the two-stage latency, so the bench can also pin down the edge on which each write becomes visible.

// File: rtl/ustep_pkg.sv
package ustep_pkg;
  localparam int CH_COUNT = 2;

  typedef struct packed {
    logic [CH_COUNT-1:0] magWr;
    logic [CH_COUNT-1:0] thrWr;
  } wrStrobes_t;
endpackage

// File: rtl/ustep_ctrl.sv
module ustep_ctrl
  import ustep_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BUS_W       = 8,
  parameter int CH_SEL_W    = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrStrobe,
  input  logic             chipSelN,
  input  logic [CH_SEL_W-1:0] chanSel,
  input  logic             regSel,
  input  logic [BUS_W-1:0] dataBus,
  output wrStrobes_t       strb,
  output logic [BUS_W-1:0] dataSync
);
  localparam int IN_W = BUS_W + CH_SEL_W + 3;

  logic [IN_W-1:0] rawIn;
  logic [SYNC_STAGES-1:0][IN_W-1:0] chain;
  logic [IN_W-1:0] synced;
  logic wrPrev;
  logic wrRise;
  logic csS;
  logic regS;
  logic [CH_SEL_W-1:0] chS;

  assign rawIn = {wrStrobe, chipSelN, regSel, chanSel, dataBus};

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      wrPrev <= 1'b0;
    end else begin
      chain  <= {chain[SYNC_STAGES-2:0], rawIn};
      wrPrev <= synced[IN_W-1];
    end
  end

  assign synced   = chain[SYNC_STAGES-1];
  assign wrRise   = synced[IN_W-1] & ~wrPrev;
  assign csS      = synced[IN_W-2];
  assign regS     = synced[IN_W-3];
  assign chS      = synced[BUS_W +: CH_SEL_W];
  assign dataSync = synced[BUS_W-1:0];

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_dec
    assign strb.magWr[c] = wrRise & ~csS & ~regS & (chS == CH_SEL_W'(c));
    assign strb.thrWr[c] = wrRise & ~csS &  regS & (chS == CH_SEL_W'(c));
  end

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    wrRise |=> !wrRise);
  assert_one_target_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.magWr, strb.thrWr}));
endmodule

// File: rtl/ustep_datapath.sv
module ustep_datapath
  import ustep_pkg::*;
#(
  parameter int MAG_W = 7,
  parameter int THR_W = 3,
  parameter int BUS_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  wrStrobes_t                      strb,
  input  logic [BUS_W-1:0]                dataSync,
  output logic [CH_COUNT-1:0][MAG_W-1:0]  dacCode,
  output logic [CH_COUNT-1:0]             signOut,
  output logic [CH_COUNT-1:0]             decayN
);
  logic [MAG_W-1:0] newCode;
  logic [THR_W-1:0] newThr;
  logic             newSign;

  assign newCode = dataSync[MAG_W-1:0];
  assign newThr  = dataSync[MAG_W-1 -: THR_W];
  assign newSign = dataSync[BUS_W-1];

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
    logic [THR_W-1:0] thr;
    logic             fastCond;

    assign fastCond = (newCode < dacCode[c]) && (newCode[MAG_W-1 -: THR_W] < thr);

    always_ff @(posedge clk) begin
      if (rst) begin
        dacCode[c] <= '0;
        signOut[c] <= 1'b0;
        decayN[c]  <= 1'b1;
        thr        <= '0;
      end else begin
        if (strb.magWr[c]) begin
          dacCode[c] <= newCode;
          signOut[c] <= newSign;
          decayN[c]  <= ~fastCond;
        end
        if (strb.thrWr[c]) thr <= newThr;
      end
    end

    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
      !strb.magWr[c] |=> ($stable(dacCode[c]) && $stable(signOut[c]) && $stable(decayN[c])));
    assert_thr_keeps_decay_R7: assert property (@(posedge clk) disable iff (rst)
      strb.thrWr[c] |=> $stable(decayN[c]));
    assert_fast_needs_drop_R6: assert property (@(posedge clk) disable iff (rst)
      strb.magWr[c] |=> (decayN[c] || (dacCode[c] < $past(dacCode[c]))));
    assert_reset_state_R8: assert property (@(posedge clk)
      rst |=> (decayN[c] && dacCode[c] == '0 && !signOut[c]));
  end
endmodule

// File: rtl/ustep_dac_front.sv
module ustep_dac_front
  import ustep_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAG_W       = 7,
  parameter int THR_W       = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wrStrobe,
  input  logic                           chipSelN,
  input  logic                           chanSel,
  input  logic                           regSel,
  input  logic [MAG_W:0]                 dataBus,
  output logic [CH_COUNT-1:0][MAG_W-1:0] dacCode,
  output logic [CH_COUNT-1:0]            signOut,
  output logic [CH_COUNT-1:0]            decayN
);
  localparam int BUS_W = MAG_W + 1;

  wrStrobes_t       strb;
  logic [BUS_W-1:0] dataSync;

  ustep_ctrl #(.SYNC_STAGES(SYNC_STAGES), .BUS_W(BUS_W), .CH_SEL_W(1)) ctrl_i (
    .clk(clk), .rst(rst), .wrStrobe(wrStrobe), .chipSelN(chipSelN),
    .chanSel(chanSel), .regSel(regSel), .dataBus(dataBus),
    .strb(strb), .dataSync(dataSync)
  );

  ustep_datapath #(.MAG_W(MAG_W), .THR_W(THR_W), .BUS_W(BUS_W)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .dataSync(dataSync),
    .dacCode(dacCode), .signOut(signOut), .decayN(decayN)
  );
endmodule

// File: tb/ustep_dac_front_tb.sv
module ustep_dac_front_tb_top;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrStrobe = 1'b0;
  logic chipSelN = 1'b1;
  logic chanSel = 1'b0;
  logic regSel = 1'b0;
  logic [7:0] dataBus = 8'h00;
  logic [1:0][6:0] dacCode;
  logic [1:0] signOut;
  logic [1:0] decayN;

  int errors = 0;
  int checks = 0;
  bit modelOn = 0;

  always #10 clk = ~clk;

  ustep_dac_front dut_i (
    .clk(clk), .rst(rst), .wrStrobe(wrStrobe), .chipSelN(chipSelN),
    .chanSel(chanSel), .regSel(regSel), .dataBus(dataBus),
    .dacCode(dacCode), .signOut(signOut), .decayN(decayN)
  );

  // reference model: raw pin history, write applied when the delayed strobe rises
  logic [11:0] hist[$];
  int mCode[2];
  int mSign[2];
  int mThr[2];
  int mDec[2];

  always @(posedge clk) begin
    logic [11:0] seen, prev, cur;
    cur = {wrStrobe, chipSelN, chanSel, regSel, dataBus};
    if (rst) begin
      hist = {};
      for (int i = 0; i <= S; i++) hist.push_back(12'h0);
      for (int c = 0; c < 2; c++) begin
        mCode[c] = 0; mSign[c] = 0; mThr[c] = 0; mDec[c] = 1;
      end
    end else begin
      seen = hist[S-1];
      prev = hist[S];
      if (seen[11] && !prev[11] && !seen[10]) begin
        int ch;
        int d;
        ch = int'(seen[9]);
        d  = int'(seen[7:0]);
        if (seen[8]) mThr[ch] = (d >> 4) & 7;
        else begin
          mDec[ch]  = ((d & 127) < mCode[ch] && ((d >> 4) & 7) < mThr[ch]) ? 0 : 1;
          mCode[ch] = d & 127;
          mSign[ch] = (d >> 7) & 1;
        end
      end
      hist.push_front(cur);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (modelOn && !rst) begin
      for (int c = 0; c < 2; c++) begin
        chk("R4 model code", int'(dacCode[c]), mCode[c]);
        chk("R4 model sign", int'(signOut[c]), mSign[c]);
        chk("R6 model decay", int'(decayN[c]), mDec[c]);
      end
    end
  end

  task automatic busWrite(input bit cs, input bit ch, input bit rg, input logic [7:0] d);
    @(negedge clk);
    chipSelN = cs; chanSel = ch; regSel = rg; dataBus = d;
    repeat (2) @(negedge clk);
    wrStrobe = 1'b1;
    repeat (4) @(negedge clk);
    wrStrobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    modelOn = 1;
    @(negedge clk);
    // R8 reset state
    chk("R8 code0", int'(dacCode[0]), 0);
    chk("R8 code1", int'(dacCode[1]), 0);
    chk("R8 sign", int'(signOut), 0);
    chk("R8 decay", int'(decayN), 3);

    busWrite(0, 0, 0, 8'h85);
    chk("R4 sign bit7", int'(signOut[0]), 1);
    chk("R4 code bits", int'(dacCode[0]), 5);
    chk("R6 rise keeps slow", int'(decayN[0]), 1);
    chk("R10 ch1 untouched", int'(dacCode[1]), 0);

    busWrite(0, 0, 1, 8'h70);
    chk("R5 code kept", int'(dacCode[0]), 5);
    chk("R7 decay kept", int'(decayN[0]), 1);

    busWrite(0, 0, 0, 8'h03);
    chk("R6 fast decay", int'(decayN[0]), 0);
    chk("R10 ch1 decay", int'(decayN[1]), 1);

    busWrite(0, 0, 1, 8'h0F);
    chk("R7 decay stays low", int'(decayN[0]), 0);
    chk("R5 sign kept", int'(signOut[0]), 0);

    busWrite(0, 0, 0, 8'h01);
    chk("R5 threshold 0 from bits 6..4", int'(decayN[0]), 1);

    busWrite(1, 1, 0, 8'h7F);
    chk("R1 cs high ignored", int'(dacCode[1]), 0);

    busWrite(0, 1, 0, 8'h7F);
    chk("R2 ch1 code", int'(dacCode[1]), 127);
    chk("R10 ch0 code", int'(dacCode[0]), 1);

    busWrite(0, 1, 1, 8'h50);
    busWrite(0, 1, 0, 8'h4F);
    chk("R6 ch1 fast", int'(decayN[1]), 0);
    chk("R10 ch0 decay", int'(decayN[0]), 1);
    busWrite(0, 1, 0, 8'h50);
    chk("R6 rise slow", int'(decayN[1]), 1);
    busWrite(0, 1, 0, 8'h4F);
    busWrite(0, 1, 0, 8'h4F);
    chk("R6 equal code slow", int'(decayN[1]), 1);
    busWrite(0, 1, 0, 8'h5A);
    busWrite(0, 1, 0, 8'h50);
    chk("R6 upper equals threshold slow", int'(decayN[1]), 1);

    // R9 latency and held strobe
    @(negedge clk);
    chipSelN = 0; chanSel = 0; regSel = 0; dataBus = 8'h22;
    @(negedge clk);
    wrStrobe = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 not yet", int'(dacCode[0]), 1);
    @(negedge clk);
    chk("R9 on time", int'(dacCode[0]), 34);
    dataBus = 8'h11;
    repeat (5) @(negedge clk);
    chk("R9 held strobe once", int'(dacCode[0]), 34);
    wrStrobe = 1'b0;
    repeat (4) @(negedge clk);

    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 reset again", int'(decayN), 3);
    chk("R8 code cleared", int'(dacCode[1]), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule